// File: doc/BRIEF.md
# Scheduled First-Order Recursive Filter Datapath

This block computes one output sample of a first-order recursive filter section:
`y = (x + d0*b0)*a1 + d0*a0 + d1*a1`. `x` is the new sample, `d0` and `d1` are the two delay-line taps, and `a0`, `a1` and `b0` are the coefficients. The block does not use one wide combinational expression. It runs the seven single-operator steps over a fixed five-cycle schedule. Two multipliers and one adder are reached through steering muxes. Four data registers are reused, so each one holds different intermediate values at different times.

A small state machine sets every mux select and register enable for each schedule slot. The caller applies operands, gives a one-cycle start pulse while the block is idle, and holds the operands stable until done. Updating the delay line and loading coefficients are the caller's job.

All data are 16-bit two's complement. A product is formed at full 32-bit precision, shifted arithmetically right by 15 (Q1.15 format), and then truncated to 16 bits. Sums wrap modulo 2^16.

Top module: `iir1_sched_dp`

## Requirements
- R1: A synchronous reset that is high at a rising edge makes `result_o` 0 and `done_o` 0 after that edge. The controller goes to idle.
- R2: After a start, `result_o` equals `(x + m(d0,b0))` fed through `m(·,a1)`, plus `m(d0,a0)`, plus `m(d1,a1)`. The operators are those defined in R3 and R4. The additions are done left to right.
- R3: Each multiply m(p,q) takes the full 32-bit signed product, shifts it arithmetically right by 15, and keeps the low 16 bits. For example, m(-32768,-32768) = -32768 (16'h8000).
- R4: Every addition is 16-bit two's complement and wraps modulo 2^16 with no saturation. For example, 16'h7FFF + 16'h2000 = 16'h9FFF.
- R5: Let edge 0 be the rising edge where `start_i` is sampled high in idle. `done_o` is high for exactly one cycle, after rising edge 5. The result is valid on `result_o` in that same cycle.
- R6: After done, `result_o` keeps its value in every cycle until the next accepted start.
- R7: A start pulse while a computation is running has no effect. The running computation finishes on its original schedule with the correct result, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle start pulse, taken only when idle |
| samp_i | input | 16 | New input sample x (signed) |
| tap0_i | input | 16 | Delay tap d0 (signed) |
| tap1_i | input | 16 | Delay tap d1 (signed) |
| fb_a0_i | input | 16 | Coefficient a0 (signed Q1.15) |
| fb_a1_i | input | 16 | Coefficient a1 (signed Q1.15) |
| ff_b0_i | input | 16 | Coefficient b0 (signed Q1.15) |
| result_o | output | 16 | Output sample y (signed) |
| done_o | output | 1 | One-cycle pulse when `result_o` becomes valid |

## Verification
The start pulse is sampled at a rising edge. After that edge the schedule adds five register stages, so the result and done are due just after the fifth following rising edge.

The bench raises start half a cycle before the sampling edge. It then waits exactly five falling edges after that edge and compares at the falling edge. It also checks that done is still low one cycle earlier and low again one cycle later. It compares `result_o` at later falling edges to show that the value holds until the next start. For the busy-start case, a second pulse is placed in the third schedule slot. The bench confirms that the first computation still finishes at its original time and that no extra done pulse follows.

// File: rtl/iir1_pkg.sv
package iir1_pkg;

    // Schedule slots of the controller
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_C1   = 3'd1,
        ST_C2   = 3'd2,
        ST_C3   = 3'd3,
        ST_C4   = 3'd4,
        ST_C5   = 3'd5
    } sched_st_e;

    // Adder operand pairing
    typedef enum logic [1:0] {
        ADD_RA_X  = 2'd0,
        ADD_RA_RB = 2'd1,
        ADD_RC_RD = 2'd2
    } add_sel_e;

    // Per-slot steering and enables
    typedef struct packed {
        logic     m0_sel;   // 0: d0*b0   1: rC*a1
        logic     m1_sel;   // 0: d0*a0   1: d1*a1
        add_sel_e add_sel;
        logic     en_a;
        logic     en_b;
        logic     en_c;
        logic     en_d;
    } dp_ctrl_t;

endpackage

// File: rtl/iir1_qmul.sv
module iir1_qmul #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 15
) (
    input  logic signed [DATA_W-1:0] op_x,
    input  logic signed [DATA_W-1:0] op_y,
    output logic signed [DATA_W-1:0] prod
);
    localparam int FULL_W = 2 * DATA_W;

    logic signed [FULL_W-1:0] full_prod;

    always_comb begin
        full_prod = $signed(FULL_W'(op_x)) * $signed(FULL_W'(op_y));
        prod      = DATA_W'(full_prod >>> FRAC_W);
    end

    // Two most-negative operands wrap back to the most-negative value
    always_comb begin
        if (op_x == {1'b1, {(DATA_W-1){1'b0}}} && op_y == {1'b1, {(DATA_W-1){1'b0}}}
            && FRAC_W == DATA_W - 1) begin
            p_minneg_wrap_r3: assert (prod == {1'b1, {(DATA_W-1){1'b0}}});
        end
    end

endmodule

// File: rtl/iir1_ctrl.sv
module iir1_ctrl
    import iir1_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output dp_ctrl_t ctrl_o,
    output logic     done_o
);
    typedef struct packed {
        sched_st_e st;
        logic      done;
    } ctrl_state_t;

    ctrl_state_t cs_d, cs_q;

    // Next state
    always_comb begin
        cs_d      = cs_q;
        cs_d.done = 1'b0;
        unique case (cs_q.st)
            ST_IDLE: if (start_i) cs_d.st = ST_C1;
            ST_C1:   cs_d.st = ST_C2;
            ST_C2:   cs_d.st = ST_C3;
            ST_C3:   cs_d.st = ST_C4;
            ST_C4:   cs_d.st = ST_C5;
            ST_C5: begin
                cs_d.st   = ST_IDLE;
                cs_d.done = 1'b1;
            end
            default: cs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= '{st: ST_IDLE, done: 1'b0};
        end else begin
            cs_q <= cs_d;
        end
    end

    // Slot decode: steering and register enables
    always_comb begin
        ctrl_o         = '0;
        ctrl_o.add_sel = ADD_RA_X;
        unique case (cs_q.st)
            ST_C1: begin
                ctrl_o.m0_sel = 1'b0;
                ctrl_o.m1_sel = 1'b0;
                ctrl_o.en_a   = 1'b1;
                ctrl_o.en_b   = 1'b1;
            end
            ST_C2: begin
                ctrl_o.m1_sel  = 1'b1;
                ctrl_o.add_sel = ADD_RA_X;
                ctrl_o.en_c    = 1'b1;
                ctrl_o.en_d    = 1'b1;
            end
            ST_C3: begin
                ctrl_o.m0_sel = 1'b1;
                ctrl_o.en_a   = 1'b1;
            end
            ST_C4: begin
                ctrl_o.add_sel = ADD_RA_RB;
                ctrl_o.en_c    = 1'b1;
            end
            ST_C5: begin
                ctrl_o.add_sel = ADD_RC_RD;
                ctrl_o.en_c    = 1'b1;
            end
            default: ;
        endcase
    end

    assign done_o = cs_q.done;

    p_idle_start_r5: assert property (@(posedge clk) disable iff (rst)
        (cs_q.st == ST_IDLE && start_i) |=> (cs_q.st == ST_C1));
    p_last_slot_done_r5: assert property (@(posedge clk) disable iff (rst)
        (cs_q.st == ST_C5) |=> (done_o && cs_q.st == ST_IDLE));
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_busy_c2_r7: assert property (@(posedge clk) disable iff (rst)
        (cs_q.st == ST_C2) |=> (cs_q.st == ST_C3));
    p_busy_c3_r7: assert property (@(posedge clk) disable iff (rst)
        (cs_q.st == ST_C3) |=> (cs_q.st == ST_C4));

endmodule

// File: rtl/iir1_datapath.sv
module iir1_datapath
    import iir1_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  dp_ctrl_t                 ctrl_i,
    input  logic signed [DATA_W-1:0] samp_i,
    input  logic signed [DATA_W-1:0] tap0_i,
    input  logic signed [DATA_W-1:0] tap1_i,
    input  logic signed [DATA_W-1:0] fb_a0_i,
    input  logic signed [DATA_W-1:0] fb_a1_i,
    input  logic signed [DATA_W-1:0] ff_b0_i,
    output logic signed [DATA_W-1:0] result_o
);
    localparam int NUM_MUL = 2;

    typedef struct packed {
        logic signed [DATA_W-1:0] ra;   // p0, then s1
        logic signed [DATA_W-1:0] rb;   // p1
        logic signed [DATA_W-1:0] rc;   // s0, then s2, then y
        logic signed [DATA_W-1:0] rd;   // p2
    } dp_regs_t;

    dp_regs_t rg_d, rg_q;

    logic signed [DATA_W-1:0] mul_x [NUM_MUL];
    logic signed [DATA_W-1:0] mul_y [NUM_MUL];
    logic signed [DATA_W-1:0] mul_p [NUM_MUL];
    logic signed [DATA_W-1:0] add_l, add_r, add_s;

    // Multiplier operand steering
    always_comb begin
        mul_x[0] = ctrl_i.m0_sel ? rg_q.rc : tap0_i;
        mul_y[0] = ctrl_i.m0_sel ? fb_a1_i : ff_b0_i;
        mul_x[1] = ctrl_i.m1_sel ? tap1_i  : tap0_i;
        mul_y[1] = ctrl_i.m1_sel ? fb_a1_i : fb_a0_i;
    end

    for (genvar g = 0; g < NUM_MUL; g++) begin : g_mul
        iir1_qmul #(
            .DATA_W(DATA_W),
            .FRAC_W(FRAC_W)
        ) u_qmul (
            .op_x(mul_x[g]),
            .op_y(mul_y[g]),
            .prod(mul_p[g])
        );
    end

    // Shared adder with steering
    always_comb begin
        unique case (ctrl_i.add_sel)
            ADD_RA_RB: begin add_l = rg_q.ra; add_r = rg_q.rb; end
            ADD_RC_RD: begin add_l = rg_q.rc; add_r = rg_q.rd; end
            default:   begin add_l = rg_q.ra; add_r = samp_i;  end
        endcase
        add_s = add_l + add_r;
    end

    // Register next values
    always_comb begin
        rg_d = rg_q;
        if (ctrl_i.en_a) rg_d.ra = mul_p[0];
        if (ctrl_i.en_b) rg_d.rb = mul_p[1];
        if (ctrl_i.en_c) rg_d.rc = add_s;
        if (ctrl_i.en_d) rg_d.rd = mul_p[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign result_o = rg_q.rc;

    // Loading register C in slot 5 places the wrapped sum of C and D there
    p_final_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.en_c && ctrl_i.add_sel == ADD_RC_RD)
        |=> (rg_q.rc == DATA_W'($past(rg_q.rc) + $past(rg_q.rd))));

endmodule

// File: rtl/iir1_sched_dp.sv
module iir1_sched_dp
    import iir1_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] samp_i,
    input  logic [DATA_W-1:0] tap0_i,
    input  logic [DATA_W-1:0] tap1_i,
    input  logic [DATA_W-1:0] fb_a0_i,
    input  logic [DATA_W-1:0] fb_a1_i,
    input  logic [DATA_W-1:0] ff_b0_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);
    dp_ctrl_t                 ctrl;
    logic signed [DATA_W-1:0] res_s;

    iir1_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .ctrl_o (ctrl),
        .done_o (done_o)
    );

    iir1_datapath #(
        .DATA_W(DATA_W),
        .FRAC_W(FRAC_W)
    ) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (ctrl),
        .samp_i  ($signed(samp_i)),
        .tap0_i  ($signed(tap0_i)),
        .tap1_i  ($signed(tap1_i)),
        .fb_a0_i ($signed(fb_a0_i)),
        .fb_a1_i ($signed(fb_a1_i)),
        .ff_b0_i ($signed(ff_b0_i)),
        .result_o(res_s)
    );

    assign result_o = res_s;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!done_o && result_o == '0));
    p_hold_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> $stable(result_o));

endmodule

// File: tb/iir1_sched_dp_bench.sv
`timescale 1ns/1ps
module iir1_sched_dp_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] x, d0, d1, a0, a1, b0;
    logic [15:0] result;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    iir1_sched_dp u_iir1_sched_dp (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .samp_i  (x),
        .tap0_i  (d0),
        .tap1_i  (d1),
        .fb_a0_i (a0),
        .fb_a1_i (a1),
        .ff_b0_i (b0),
        .result_o(result),
        .done_o  (done)
    );

    // Stimulus table: {x, d0, d1, a0, a1, b0}
    localparam int NVEC = 8;
    localparam logic [95:0] VECS [NVEC] = '{
        {16'h1000, 16'h2000, 16'h0800, 16'h4000, 16'h4000, 16'h4000},
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {16'hF000, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF},
        {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
        {16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
        {16'h0123, 16'hFEDC, 16'h3456, 16'hC000, 16'h2000, 16'hE000},
        {16'h0001, 16'hFFFF, 16'h0001, 16'h7FFF, 16'h0001, 16'h8000},
        {16'h5A5A, 16'hA5A5, 16'h1234, 16'h0F0F, 16'hF0F0, 16'h3C3C}
    };

    function automatic logic [15:0] ref_mul(input logic [15:0] p, input logic [15:0] q);
        logic signed [31:0] full;
        full = $signed({{16{p[15]}}, p}) * $signed({{16{q[15]}}, q});
        return full[30:15];
    endfunction

    function automatic logic [15:0] ref_out(input logic [15:0] vx, input logic [15:0] vd0,
                                            input logic [15:0] vd1, input logic [15:0] va0,
                                            input logic [15:0] va1, input logic [15:0] vb0);
        logic [15:0] t;
        t = vx + ref_mul(vd0, vb0);
        t = ref_mul(t, va1);
        t = t + ref_mul(vd0, va0);
        t = t + ref_mul(vd1, va1);
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply operands, pulse start, check timing and value; ends at the done cycle
    task automatic run_one(input logic [95:0] v, input string req, input bit busy_poke);
        logic [15:0] exp;
        {x, d0, d1, a0, a1, b0} = v;
        exp = ref_out(x, d0, d1, a0, a1, b0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);            // edge 0 has sampled start
        start = 1'b0;
        repeat (2) @(negedge clk); // after edge 2, in slot 3
        if (busy_poke) start = 1'b1;
        @(negedge clk);            // after edge 3
        start = 1'b0;
        @(negedge clk);            // after edge 4
        check(done == 1'b0, "R5 done early", {15'd0, done}, 16'd0);
        @(negedge clk);            // after edge 5
        check(done == 1'b1, "R5 done due", {15'd0, done}, 16'd1);
        check(result == exp, req, result, exp);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", {15'd0, done}, 16'd0);
        check(result == exp, "R6 result held", result, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        {x, d0, d1, a0, a1, b0} = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(result == 16'h0000, "R1 result", result, 16'h0000);
        check(done == 1'b0, "R1 done", {15'd0, done}, 16'd0);
        rst = 1'b0;

        // R2: table walk
        for (int i = 0; i < NVEC; i++) run_one(VECS[i], "R2 table", 1'b0);

        // R3: most-negative product wraps: y = 16'h8000
        run_one({16'h0000, 16'h8000, 16'h0000, 16'h0000, 16'h8000, 16'h8000}, "R3 minneg", 1'b0);
        check(result == 16'h8000, "R3 minneg literal", result, 16'h8000);

        // R4: first addition wraps (7FFF + 2000 = 9FFF); a1 = 0.5, others zero
        // y = m(9FFF, 4000) = 16'hCFFF
        run_one({16'h7FFF, 16'h4000, 16'h0000, 16'h0000, 16'h4000, 16'h4000}, "R4 wrap", 1'b0);
        check(result == 16'hCFFF, "R4 wrap literal", result, 16'hCFFF);

        // R6: result stays while idle for several cycles
        begin
            logic [15:0] held;
            held = result;
            x = 16'h1111; d0 = 16'h2222; d1 = 16'h3333;
            repeat (6) @(negedge clk);
            check(result == held, "R6 idle hold", result, held);
            check(done == 1'b0, "R6 no done idle", {15'd0, done}, 16'd0);
        end

        // R7: start during slot 3 ignored
        run_one({16'h0400, 16'h3000, 16'hD000, 16'h2000, 16'h6000, 16'hA000}, "R7 busy start result", 1'b1);
        begin
            logic [15:0] held;
            bit extra_done;
            held = result;
            extra_done = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done) extra_done = 1'b1;
            end
            check(!extra_done, "R7 no extra done", {15'd0, extra_done}, 16'd0);
            check(result == held, "R7 result unchanged", result, held);
        end

        // R2: random operands
        for (int i = 0; i < 40; i++) begin
            run_one({16'($urandom), 16'($urandom), 16'($urandom),
                     16'($urandom), 16'($urandom), 16'($urandom)}, "R2 random", 1'b0);
        end

        // R1: reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(result == 16'h0000, "R1 re-reset result", result, 16'h0000);
        check(done == 1'b0, "R1 re-reset done", {15'd0, done}, 16'd0);
        rst = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule